// File: doc/BRIEF.md
# PIO Sector Transfer Sequencer

This block is the device-side engine that carries sector data across a 16-bit programmed-I/O data port for the ATA data-in and data-out commands. A decoder upstream hands it a command strobe with the opcode and the sector-count value. The engine then moves whole sectors between the host port and a sector buffer, which presents a simple valid/ready word stream in each direction. It drives the busy (BSY), data-request (DRQ), interrupt and abort-error outputs that the host polls or waits on.

A local one-sector store sits between the two sides. On data-in commands a complete sector is fetched from the buffer before DRQ rises. On data-out commands the host fills the store under DRQ, and the engine then drains it to the buffer while busy. The same sequencer also handles several command variants:

- Multiple-block commands interrupt once per block, using a block size set by a separate command.
- Long commands carry two extra words.
- Verify fetches sectors but hands nothing to the host.
- NOP and any opcode the engine does not know are rejected as aborted.

Top module: `pio_sector_seq`

## Requirements
- R1: While reset is held and on leaving it, bsy, drq, intrq, aborted, buf_in_ready and buf_out_valid are all 0.
- R2: A command's sector-count value N in 1..255 moves exactly N sectors, and the value 0 moves 256 sectors.
- R3: A sector is WORDS_PER_SEC 16-bit words, and they pass in order. On a data-in command, DRQ rises only after all words of the sector have been taken from the buffer.
- R4: The single-sector read opcodes 20h/21h raise intrq in the same cycle that each sector's DRQ rises. The write opcodes 30h/31h raise intrq after each sector has been passed to the buffer.
- R5: Read-multiple C4h raises intrq only when the first sector of each block becomes ready. Write-multiple C5h raises it only after the last sector of each block. A shorter final block still gives exactly one interrupt, so a command gives ceil(N/B) interrupts for block size B.
- R6: Set-multiple C6h takes its block size from the sector-count value. A value in 1..MAX_MULT is stored and completes with intrq and no error. A value of 0 or above MAX_MULT aborts, and the previously stored size stays in force.
- R7: C4h or C5h issued while no valid block size has been stored since reset is aborted and moves no data.
- R8: Read-long 22h/23h moves one sector regardless of the count value. The sector is followed by 2 extra words that read as 0000h.
- R9: Write-long 32h/33h accepts one sector plus 2 extra words from the host. Only the first WORDS_PER_SEC words reach the buffer.
- R10: Verify 40h/41h takes N sectors from the buffer, never raises DRQ, and raises intrq once when the last sector has been taken.
- R11: NOP 00h and every opcode not named in R4 to R10 completes at once with aborted=1 and intrq=1. BSY and DRQ stay low, and no data moves.
- R12: bsy and drq are never high together. A cmd_valid strobe while a command is in progress is ignored.
- R13: intrq stays high until int_clr is pulsed; a new interrupt in the same cycle wins over the clear. aborted stays high until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | 8 | Sector-count value (block size for C6h) |
| hst_rd | input | 1 | Host read strobe on the data port |
| hst_wr | input | 1 | Host write strobe on the data port |
| hst_wdata | input | 16 | Word written by the host |
| hst_rdata | output | 16 | Word presented to the host |
| drq | output | 1 | Data request |
| bsy | output | 1 | Busy |
| intrq | output | 1 | Sticky interrupt request |
| aborted | output | 1 | Last command was aborted |
| int_clr | input | 1 | Clears intrq |
| buf_in_valid | input | 1 | Buffer offers a data-in word |
| buf_in_data | input | 16 | Data-in word from the buffer |
| buf_in_ready | output | 1 | Engine takes a data-in word |
| buf_out_valid | output | 1 | Engine offers a data-out word |
| buf_out_data | output | 16 | Data-out word to the buffer |
| buf_out_ready | input | 1 | Buffer takes the data-out word |

## Verification
The bench builds the engine with four words per sector and a largest block size of four. With that setting, a 256-sector transfer takes only a few thousand cycles. It also lets the bench sweep every legal block size against counts from 1 to 7, so it covers full blocks, short final blocks and single-block commands. The out-of-range block sizes 0 and 5 are directly reachable. Every expected data word, interrupt count and buffer word count is derived arithmetically from the opcode, count and block size. Some passes also pause the buffer handshake on both sides.

// File: rtl/pse_pkg.sv
package pse_pkg;

    // Command classes produced by the opcode decoder
    typedef enum logic [3:0] {
        OP_ABORT,
        OP_RD,
        OP_RDM,
        OP_RDL,
        OP_VER,
        OP_WR,
        OP_WRM,
        OP_WRL,
        OP_SETM
    } op_cls_e;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,   // taking a sector from the buffer (busy)
        S_SEND,    // host reading the sector (drq)
        S_TAKE,    // host writing the sector (drq)
        S_DRAIN    // passing the sector to the buffer (busy)
    } st_e;

endpackage

// File: rtl/pse_decode.sv
module pse_decode
    import pse_pkg::*;
(
    input  logic [7:0] opcode,
    output op_cls_e    cls
);

    always_comb begin
        unique case (opcode)
            8'h20, 8'h21: cls = OP_RD;
            8'hC4:        cls = OP_RDM;
            8'h22, 8'h23: cls = OP_RDL;
            8'h40, 8'h41: cls = OP_VER;
            8'h30, 8'h31: cls = OP_WR;
            8'hC5:        cls = OP_WRM;
            8'h32, 8'h33: cls = OP_WRL;
            8'hC6:        cls = OP_SETM;
            default:      cls = OP_ABORT;  // NOP 00h and all unknown codes
        endcase
    end

endmodule

// File: rtl/pse_blkreg.sv
module pse_blkreg #(
    parameter int MAX_MULT = 16,
    localparam int BW = $clog2(MAX_MULT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_val,
    output logic          wr_ok,
    output logic [BW-1:0] blk_size,
    output logic          blk_valid
);

    typedef struct packed {
        logic [BW-1:0] size;
        logic          valid;
    } blk_t;

    blk_t q, d;

    assign wr_ok = (wr_val != 8'd0) && (wr_val <= 8'(MAX_MULT));

    always_comb begin
        d = q;
        if (wr_en && wr_ok) begin
            d.size  = BW'(wr_val);
            d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign blk_size  = q.size;
    assign blk_valid = q.valid;

    assert_blk_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (blk_size >= BW'(1)) && (32'(blk_size) <= MAX_MULT));

    assert_blk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_ok) |=> $stable(blk_size) && $stable(blk_valid));

endmodule

// File: rtl/pse_secbuf.sv
module pse_secbuf #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pio_sector_seq.sv
module pio_sector_seq
    import pse_pkg::*;
#(
    parameter int WORDS_PER_SEC = 256,
    parameter int MAX_MULT      = 16,
    parameter int DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [7:0]        cmd_count,
    input  logic              hst_rd,
    input  logic              hst_wr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              drq,
    output logic              bsy,
    output logic              intrq,
    output logic              aborted,
    input  logic              int_clr,
    input  logic              buf_in_valid,
    input  logic [DATA_W-1:0] buf_in_data,
    output logic              buf_in_ready,
    output logic              buf_out_valid,
    output logic [DATA_W-1:0] buf_out_data,
    input  logic              buf_out_ready
);

    localparam int EXTRA_W = 2;  // four appended bytes on long commands
    localparam int AW      = $clog2(WORDS_PER_SEC);
    localparam int IW      = $clog2(WORDS_PER_SEC + EXTRA_W + 1);
    localparam int BW      = $clog2(MAX_MULT + 1);
    localparam logic [IW-1:0] LAST_SEC  = IW'(WORDS_PER_SEC - 1);
    localparam logic [IW-1:0] LAST_LONG = IW'(WORDS_PER_SEC + EXTRA_W - 1);
    localparam logic [IW-1:0] SEC_WORDS = IW'(WORDS_PER_SEC);

    typedef struct packed {
        st_e           st;
        op_cls_e       cls;
        logic [IW-1:0] idx;
        logic [8:0]    secs;
        logic [BW-1:0] bcnt;
        logic [BW-1:0] bsz;
        logic          intrq;
        logic          err;
    } seq_t;

    seq_t q, d;

    op_cls_e           dec_cls;
    logic              bset_en, bset_ok, blk_valid;
    logic [BW-1:0]     blk_size;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [IW-1:0]     idx_last;
    logic              sec_end, blk_end, in_sector;

    pse_decode u_dec (
        .opcode (cmd_op),
        .cls    (dec_cls)
    );

    pse_blkreg #(.MAX_MULT(MAX_MULT)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bset_en),
        .wr_val    (cmd_count),
        .wr_ok     (bset_ok),
        .blk_size  (blk_size),
        .blk_valid (blk_valid)
    );

    pse_secbuf #(.DEPTH(WORDS_PER_SEC), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (q.idx[AW-1:0]),
        .wdata (mem_wdata),
        .raddr (q.idx[AW-1:0]),
        .rdata (mem_rdata)
    );

    assign idx_last  = (q.cls == OP_RDL || q.cls == OP_WRL) ? LAST_LONG : LAST_SEC;
    assign sec_end   = (q.secs == 9'd1);
    assign blk_end   = (q.bcnt == q.bsz - BW'(1));
    assign in_sector = (q.idx < SEC_WORDS);

    always_comb begin
        d             = q;
        mem_we        = 1'b0;
        mem_wdata     = hst_wdata;
        buf_in_ready  = 1'b0;
        buf_out_valid = 1'b0;
        bset_en       = 1'b0;

        if (int_clr) d.intrq = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    d.err  = 1'b0;
                    d.idx  = '0;
                    d.bcnt = '0;
                    d.bsz  = BW'(1);
                    d.cls  = dec_cls;
                    d.secs = (cmd_count == 8'd0) ? 9'd256 : {1'b0, cmd_count};
                    unique case (dec_cls)
                        OP_RD, OP_VER: d.st = S_FETCH;
                        OP_WR:         d.st = S_TAKE;
                        OP_RDL: begin
                            d.secs = 9'd1;
                            d.st   = S_FETCH;
                        end
                        OP_WRL: begin
                            d.secs = 9'd1;
                            d.st   = S_TAKE;
                        end
                        OP_RDM, OP_WRM: begin
                            if (blk_valid) begin
                                d.bsz = blk_size;
                                d.st  = (dec_cls == OP_RDM) ? S_FETCH : S_TAKE;
                            end else begin
                                d.err   = 1'b1;
                                d.intrq = 1'b1;
                            end
                        end
                        OP_SETM: begin
                            bset_en = 1'b1;
                            d.intrq = 1'b1;
                            d.err   = !bset_ok;
                        end
                        default: begin
                            d.err   = 1'b1;
                            d.intrq = 1'b1;
                        end
                    endcase
                end
            end

            S_FETCH: begin
                buf_in_ready = 1'b1;
                mem_wdata    = buf_in_data;
                if (buf_in_valid) begin
                    mem_we = (q.cls != OP_VER);
                    d.idx  = q.idx + IW'(1);
                    if (q.idx == LAST_SEC) begin
                        d.idx = '0;
                        if (q.cls == OP_VER) begin
                            d.secs = q.secs - 9'd1;
                            if (sec_end) begin
                                d.st    = S_IDLE;
                                d.intrq = 1'b1;
                            end
                        end else begin
                            d.st = S_SEND;
                            if (q.bcnt == '0) d.intrq = 1'b1;
                        end
                    end
                end
            end

            S_SEND: begin
                if (hst_rd) begin
                    d.idx = q.idx + IW'(1);
                    if (q.idx == idx_last) begin
                        d.idx  = '0;
                        d.secs = q.secs - 9'd1;
                        d.bcnt = blk_end ? '0 : q.bcnt + BW'(1);
                        d.st   = sec_end ? S_IDLE : S_FETCH;
                    end
                end
            end

            S_TAKE: begin
                if (hst_wr) begin
                    mem_we = in_sector;
                    d.idx  = q.idx + IW'(1);
                    if (q.idx == idx_last) begin
                        d.idx = '0;
                        d.st  = S_DRAIN;
                    end
                end
            end

            S_DRAIN: begin
                buf_out_valid = 1'b1;
                if (buf_out_ready) begin
                    d.idx = q.idx + IW'(1);
                    if (q.idx == LAST_SEC) begin
                        d.idx  = '0;
                        d.secs = q.secs - 9'd1;
                        d.bcnt = blk_end ? '0 : q.bcnt + BW'(1);
                        if (blk_end || sec_end) d.intrq = 1'b1;
                        d.st   = sec_end ? S_IDLE : S_TAKE;
                    end
                end
            end

            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_IDLE;
            q.cls <= OP_ABORT;
        end else begin
            q <= d;
        end
    end

    assign bsy          = (q.st == S_FETCH) || (q.st == S_DRAIN);
    assign drq          = (q.st == S_SEND)  || (q.st == S_TAKE);
    assign intrq        = q.intrq;
    assign aborted      = q.err;
    assign hst_rdata    = (q.st == S_SEND && in_sector) ? mem_rdata : '0;
    assign buf_out_data = mem_rdata;

    assert_bsy_drq_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy && drq));

    assert_cmd_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE && cmd_valid) |=> $stable(q.cls) && $stable(aborted));

    assert_secs_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |-> (q.secs != 9'd0));

    assert_full_sector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drq) && q.st == S_SEND) |-> $past(buf_in_valid && buf_in_ready));

    assert_long_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_TAKE && hst_wr && !in_sector) |-> !mem_we);

    assert_verify_nodrq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cls == OP_VER) |-> !drq);

    assert_abort_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted) |-> intrq);

endmodule

// File: tb/sim_pio_sector_seq.sv
`timescale 1ns/1ps
module sim_pio_sector_seq;

    localparam int W  = 4;
    localparam int MM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [7:0]  cmd_count = 8'h00;
    logic        hst_rd = 1'b0;
    logic        hst_wr = 1'b0;
    logic [15:0] hst_wdata = 16'h0;
    logic [15:0] hst_rdata;
    logic        drq, bsy, intrq, aborted;
    logic        int_clr = 1'b0;
    logic        buf_in_valid = 1'b0;
    logic [15:0] buf_in_data = 16'h0;
    logic        buf_in_ready;
    logic        buf_out_valid;
    logic [15:0] buf_out_data;
    logic        buf_out_ready = 1'b0;

    always #2.5 clk = ~clk;

    pio_sector_seq #(.WORDS_PER_SEC(W), .MAX_MULT(MM), .DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .hst_rd(hst_rd), .hst_wr(hst_wr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .drq(drq), .bsy(bsy),
        .intrq(intrq), .aborted(aborted), .int_clr(int_clr),
        .buf_in_valid(buf_in_valid), .buf_in_data(buf_in_data),
        .buf_in_ready(buf_in_ready), .buf_out_valid(buf_out_valid),
        .buf_out_data(buf_out_data), .buf_out_ready(buf_out_ready)
    );

    int n_chk = 0, n_fail = 0;
    int src_taken = 0, sink_n = 0, wq_n = 0, irq_n = 0, cyc = 0, overlap = 0;
    bit stall = 1'b0, mon_en = 1'b1, src_fire = 1'b0, done = 1'b0;
    logic [15:0] sink_mem [0:8191];
    logic [15:0] wq_mem   [0:8191];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Buffer models and interrupt monitor, all acting at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (src_fire) src_taken++;
        buf_in_valid = stall ? ((cyc % 3) != 2) : 1'b1;
        buf_in_data  = 16'h1000 + 16'(src_taken);
        src_fire     = buf_in_valid && buf_in_ready;
        buf_out_ready = stall ? ((cyc % 4) != 1) : 1'b1;
        if (buf_out_valid && buf_out_ready) begin
            sink_mem[sink_n] = buf_out_data;
            sink_n++;
        end
        if (bsy && drq) overlap++;
        if (mon_en) begin
            if (intrq && !int_clr) begin
                irq_n++;
                int_clr = 1'b1;
            end else begin
                int_clr = 1'b0;
            end
        end
    end

    // kind: 0 read, 1 write, 2 verify, 3 aborted, 4 set-multiple accepted
    task automatic do_cmd(input string tag, input logic [7:0] op, input logic [7:0] cnt,
                          input int kind, input int blk, input bit poke);
        bit lng, drq_seen;
        int s, wlen, exp_irq, src0, sink0, wq0, irq0, bad, sec, wi;
        logic [15:0] ev;
        lng = (op == 8'h22) || (op == 8'h23) || (op == 8'h32) || (op == 8'h33);
        s = lng ? 1 : ((cnt == 8'd0) ? 256 : int'(cnt));
        wlen = lng ? W + 2 : W;
        exp_irq = (kind <= 1) ? (s + blk - 1) / blk : 1;
        src0 = src_taken; sink0 = sink_n; wq0 = wq_n; irq0 = irq_n;
        bad = 0; sec = 0; wi = 0; drq_seen = 1'b0;
        @(negedge clk); #1;
        cmd_op = op; cmd_count = cnt; cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        if (poke) begin
            cmd_op = 8'h00; cmd_valid = 1'b1;
            @(negedge clk); #1;
            cmd_valid = 1'b0;
        end
        forever begin
            if (!bsy && !drq) break;
            if (drq) begin
                drq_seen = 1'b1;
                if (kind == 1) begin
                    hst_wdata = 16'hA000 + 16'(wq_n);
                    wq_mem[wq_n] = hst_wdata;
                    wq_n++;
                    hst_wr = 1'b1;
                end else begin
                    if (wi == 0 && (src_taken - src0) != (sec + 1) * W) bad++;
                    ev = (wi < W) ? 16'h1000 + 16'(src0 + sec * W + wi) : 16'h0000;
                    if (hst_rdata !== ev) bad++;
                    hst_rd = 1'b1;
                    wi++;
                    if (wi == wlen) begin wi = 0; sec++; end
                end
            end
            @(negedge clk); #1;
            hst_rd = 1'b0; hst_wr = 1'b0;
        end
        chk(bad == 0, {tag, " host words/ordering"}, bad, 0);
        chk(irq_n - irq0 == exp_irq, {tag, " interrupt count"}, irq_n - irq0, exp_irq);
        chk(aborted == (kind == 3), {tag, " abort flag"}, int'(aborted), int'(kind == 3));
        if (kind == 0 || kind == 2)
            chk(src_taken - src0 == s * W, {tag, " buffer words taken"}, src_taken - src0, s * W);
        if (kind == 2)
            chk(!drq_seen, {tag, " drq during verify"}, int'(drq_seen), 0);
        if (kind == 1) begin
            chk(sink_n - sink0 == s * W, {tag, " buffer words given"}, sink_n - sink0, s * W);
            bad = 0;
            for (int i = 0; i < s * W; i++)
                if (sink_mem[sink0 + i] !== wq_mem[wq0 + (i / W) * wlen + (i % W)]) bad++;
            chk(bad == 0, {tag, " buffer word values"}, bad, 0);
        end
        if (kind >= 3)
            chk(src_taken == src0 && sink_n == sink0 && !drq_seen, {tag, " no data moved"},
                (src_taken - src0) + (sink_n - sink0), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!bsy && !drq && !intrq && !aborted, "R1 outputs in reset", int'({bsy, drq, intrq, aborted}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!bsy && !drq && !intrq && !aborted && !buf_in_ready && !buf_out_valid,
            "R1 outputs after reset", int'({bsy, drq, intrq, aborted, buf_in_ready, buf_out_valid}), 0);

        do_cmd("R11 nop", 8'h00, 8'd1, 3, 1, 0);
        do_cmd("R11 unknown 90h", 8'h90, 8'd1, 3, 1, 0);
        do_cmd("R11 unknown C8h", 8'hC8, 8'd2, 3, 1, 0);
        do_cmd("R7 read-multiple unset", 8'hC4, 8'd2, 3, 1, 0);
        do_cmd("R7 write-multiple unset", 8'hC5, 8'd2, 3, 1, 0);
        do_cmd("R6 set-multiple zero", 8'hC6, 8'd0, 3, 1, 0);
        do_cmd("R6 set-multiple over", 8'hC6, 8'(MM + 1), 3, 1, 0);
        do_cmd("R7 read-multiple after bad set", 8'hC4, 8'd2, 3, 1, 0);

        for (int c = 1; c <= 3; c++) begin
            do_cmd("R4 read 20h", 8'h20, 8'(c), 0, 1, 0);
            do_cmd("R4 read 21h", 8'h21, 8'(c), 0, 1, 0);
            do_cmd("R4 write 30h", 8'h30, 8'(c), 1, 1, 0);
            do_cmd("R4 write 31h", 8'h31, 8'(c), 1, 1, 0);
        end
        do_cmd("R2 read count 0", 8'h20, 8'd0, 0, 1, 0);
        do_cmd("R2 write count 0", 8'h30, 8'd0, 1, 1, 0);
        do_cmd("R2 read count 255", 8'h21, 8'd255, 0, 1, 0);

        stall = 1'b1;
        do_cmd("R3 read with stalls", 8'h20, 8'd5, 0, 1, 0);
        do_cmd("R3 write with stalls", 8'h30, 8'd5, 1, 1, 0);

        for (int b = 1; b <= MM; b++) begin
            do_cmd("R6 set-multiple legal", 8'hC6, 8'(b), 4, 1, 0);
            for (int c = 1; c <= 7; c++) begin
                do_cmd("R5 read-multiple", 8'hC4, 8'(c), 0, b, 0);
                do_cmd("R5 write-multiple", 8'hC5, 8'(c), 1, b, 0);
            end
        end
        stall = 1'b0;
        do_cmd("R6 set-multiple 3", 8'hC6, 8'd3, 4, 1, 0);
        do_cmd("R5 read-multiple count 0", 8'hC4, 8'd0, 0, 3, 0);
        do_cmd("R5 write-multiple count 0", 8'hC5, 8'd0, 1, 3, 0);
        do_cmd("R6 bad set keeps size", 8'hC6, 8'(MM + 1), 3, 1, 0);
        do_cmd("R6 size 3 still used", 8'hC4, 8'd7, 0, 3, 0);

        do_cmd("R8 read-long 22h", 8'h22, 8'd5, 0, 1, 0);
        do_cmd("R8 read-long 23h", 8'h23, 8'd0, 0, 1, 0);
        do_cmd("R9 write-long 32h", 8'h32, 8'd3, 1, 1, 0);
        do_cmd("R9 write-long 33h", 8'h33, 8'd1, 1, 1, 0);

        do_cmd("R10 verify 40h", 8'h40, 8'd3, 2, 1, 0);
        do_cmd("R10 verify 41h count 0", 8'h41, 8'd0, 2, 1, 0);

        do_cmd("R12 strobe during read", 8'h20, 8'd2, 0, 1, 1);
        do_cmd("R12 strobe during write", 8'h30, 8'd2, 1, 1, 1);
        chk(overlap == 0, "R12 bsy and drq together", overlap, 0);

        // R13: sticky interrupt and error under manual clearing
        mon_en = 1'b0;
        @(negedge clk); #1;
        int_clr = 1'b0;
        cmd_op = 8'h00; cmd_count = 8'd1; cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(intrq == 1'b1, "R13 intrq held without clear", int'(intrq), 1);
        int_clr = 1'b1;
        @(negedge clk); #1;
        int_clr = 1'b0;
        chk(intrq == 1'b0, "R13 intrq after clear", int'(intrq), 0);
        chk(aborted == 1'b1, "R13 aborted held", int'(aborted), 1);
        mon_en = 1'b1;
        do_cmd("R13 next command clears abort", 8'hC6, 8'd2, 4, 1, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule